// File: doc/BRIEF.md
# Bus-Mapped Wide Dual-Port Memory

This block is a single-clock memory that has two ways in. The application side uses a wide user port. Each user address holds one whole word of `WORD_W` bits, which is read and written in one cycle. The control side uses a 16-bit register bus that reaches the same storage. Each user word is cut into 16-bit pieces, least significant piece first. Every piece has its own bank of `DEPTH` bus addresses. The banks sit back to back starting at `BASE_ADDR`.

When `WORD_W` is not a multiple of 16, the top bank holds only the leftover bits. On the bus those leftover bits are zero-extended to 16 bits. Both ports can read and write at any time.

A bus write changes only the piece it addresses, and leaves the rest of the user word as it was. If both ports write the same user word in the same cycle, the user port wins.

Top module: `bmem_wide_dpram`

## Requirements
- R1: After reset every location reads as zero through both ports, `usr_rdata` is zero and `bus_rvalid` is low.
- R2: Piece i of user word a (bits 16i+15 down to 16i) appears at bus address `BASE_ADDR + i*DEPTH + a`. Piece 0 is the least significant.
- R3: The top piece carries `WORD_W mod 16` bits when that remainder is nonzero. Its unused upper bus bits read as zero, and bus writes to them are discarded.
- R4: `usr_rdata` is registered. After each clock edge it shows the word at the `usr_addr` sampled at that edge, as the word stood before any write made at that same edge.
- R5: With `usr_we` high, the full `usr_wdata` word is stored at `usr_addr` on the clock edge. Later bus reads return its pieces.
- R6: A bus write inside the window replaces only the addressed piece of the user word. All other pieces are kept.
- R7: A bus read sampled at edge k drives `bus_rdata` with `bus_rvalid` high for exactly one cycle after edge k+1. The data is the contents before any write made at edge k.
- R8: Bus accesses below `BASE_ADDR` or at or above `BASE_ADDR + slices*DEPTH` are ignored. Writes change nothing, and reads raise no `bus_rvalid`.
- R9: When both ports write the same user word in one cycle, the user write is stored and the bus write is dropped. Writes by the two ports to different words in one cycle both take effect.
- R10: Any interleaving of reads and writes on both ports matches a per-address model of the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset; clears all storage |
| usr_addr | input | $clog2(DEPTH) | User word address |
| usr_we | input | 1 | User write enable |
| usr_wdata | input | WORD_W | User write word |
| usr_rdata | output | WORD_W | Registered user read word |
| bus_addr | input | 16 | Bus register address |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | One-cycle strobe marking returned bus read data |

## Verification
The user read word is due one clock edge after its address is sampled. Bus read data and its strobe are due two edges after the request. A write is visible to any read sampled at a later edge, but not to one sampled at the same edge.

The bench drives inputs on the falling edge and keeps a behavioural model that advances on every rising edge. On each falling edge it compares both read paths against that model. This means every check samples half a cycle after the edge at which the result is due.

Directed sequences add known values at the piece boundaries, in the partial top piece, just outside both ends of the window, and on same-word and different-word write collisions.

// File: rtl/bmem_pkg.sv
package bmem_pkg;

   localparam int BUS_W = 16;

   // number of bus-sized pieces needed to cover a word
   function automatic int slice_total(input int word_w);
      return (word_w + BUS_W - 1) / BUS_W;
   endfunction

   // width of piece idx of a word_w-bit word
   function automatic int slice_bits(input int word_w, input int idx);
      if (idx < word_w / BUS_W) return BUS_W;
      return word_w % BUS_W;
   endfunction

endpackage

// File: rtl/bmem_bus_decode.sv
module bmem_bus_decode #(
   parameter int unsigned BASE_ADDR = 0,
   parameter int unsigned DEPTH     = 512,
   parameter int unsigned NSLICE    = 2,
   parameter int unsigned AW        = 9,
   parameter int unsigned SIW       = 1
) (
   input  logic [15:0]     addr,
   output logic            hit,
   output logic [SIW-1:0]  slice,
   output logic [AW-1:0]   offset
);

   localparam logic [31:0] BASE_U  = 32'(BASE_ADDR);
   localparam logic [31:0] DEPTH_U = 32'(DEPTH);
   localparam logic [31:0] SPAN_U  = 32'(NSLICE * DEPTH);

   logic [31:0] addr_w;
   logic [31:0] rel;

   always_comb begin
      addr_w = {16'd0, addr};
      rel    = addr_w - BASE_U;
      hit    = (addr_w >= BASE_U) && (rel < SPAN_U);
      slice  = '0;
      offset = '0;
      // ascending scan: the last bank whose start lies at or below rel wins
      for (int s = 0; s < int'(NSLICE); s++) begin
         if (hit && (rel >= DEPTH_U * 32'(s))) begin
            slice  = SIW'(s);
            offset = AW'(rel - DEPTH_U * 32'(s));
         end
      end
   end

endmodule

// File: rtl/bmem_slice_bank.sv
module bmem_slice_bank #(
   parameter int unsigned SW    = 16,
   parameter int unsigned DEPTH = 512,
   parameter int unsigned AW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          u_we,
   input  logic [AW-1:0] u_addr,
   input  logic [SW-1:0] u_wd,
   input  logic          b_we,
   input  logic [AW-1:0] b_addr,
   input  logic [SW-1:0] b_wd,
   output logic [SW-1:0] u_rd,
   output logic [SW-1:0] b_rd
);

   logic [SW-1:0] mem [DEPTH];

   // two write ports; the user port is tested first and so wins a same-entry clash
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      end else begin
         for (int i = 0; i < int'(DEPTH); i++) begin
            if (u_we && (u_addr == AW'(i)))      mem[i] <= u_wd;
            else if (b_we && (b_addr == AW'(i))) mem[i] <= b_wd;
         end
      end
   end

   // asynchronous reads; the caller registers them
   always_comb begin
      u_rd = (32'(u_addr) < 32'(DEPTH)) ? mem[u_addr] : '0;
      b_rd = (32'(b_addr) < 32'(DEPTH)) ? mem[b_addr] : '0;
   end

   // R9: user data lands when both ports hit one entry in the same cycle
   a_r9_user_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (u_we && b_we && (u_addr == b_addr)) |=> (mem[$past(u_addr)] == $past(u_wd)));

endmodule

// File: rtl/bmem_bus_rdpipe.sv
module bmem_bus_rdpipe #(
   parameter int unsigned NSLICE = 2,
   parameter int unsigned SIW    = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req,
   input  logic [SIW-1:0]          slice,
   input  logic [NSLICE-1:0][15:0] slice_rd,
   output logic [15:0]             rdata,
   output logic                    rvalid
);

   logic        s1_v;
   logic [15:0] s1_d;

   // stage 1 captures the pre-write contents; stage 2 drives the bus
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v   <= 1'b0;
         s1_d   <= '0;
         rvalid <= 1'b0;
         rdata  <= '0;
      end else begin
         s1_v   <= req;
         s1_d   <= req ? slice_rd[slice] : 16'd0;
         rvalid <= s1_v;
         rdata  <= s1_v ? s1_d : 16'd0;
      end
   end

endmodule

// File: rtl/bmem_wide_dpram.sv
module bmem_wide_dpram #(
   parameter int unsigned WORD_W    = 23,
   parameter int unsigned DEPTH     = 512,
   parameter int unsigned BASE_ADDR = 16'h0040
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [$clog2(DEPTH)-1:0]  usr_addr,
   input  logic                      usr_we,
   input  logic [WORD_W-1:0]         usr_wdata,
   output logic [WORD_W-1:0]         usr_rdata,
   input  logic [15:0]               bus_addr,
   input  logic                      bus_we,
   input  logic                      bus_re,
   input  logic [15:0]               bus_wdata,
   output logic [15:0]               bus_rdata,
   output logic                      bus_rvalid
);

   localparam int unsigned NSLICE = bmem_pkg::slice_total(int'(WORD_W));
   localparam int unsigned REM    = WORD_W % 16;
   localparam int unsigned AW     = $clog2(DEPTH);
   localparam int unsigned SIW    = (NSLICE > 1) ? $clog2(NSLICE) : 1;
   localparam int unsigned LAST   = NSLICE - 1;

   // elaboration-time parameter checks
   if (WORD_W < 1) begin : g_chk_w
      $error("bmem_wide_dpram: WORD_W must be at least 1");
   end
   if (DEPTH < 2) begin : g_chk_d
      $error("bmem_wide_dpram: DEPTH must be at least 2");
   end
   if (BASE_ADDR + NSLICE * DEPTH > 65536) begin : g_chk_span
      $error("bmem_wide_dpram: bus window runs past the 16-bit address space");
   end

   logic                    dec_hit;
   logic [SIW-1:0]          dec_slice;
   logic [AW-1:0]           dec_off;
   logic [WORD_W-1:0]       usr_word;
   logic [NSLICE-1:0][15:0] slice_rd;
   logic                    rd_req;

   bmem_bus_decode #(
      .BASE_ADDR (BASE_ADDR),
      .DEPTH     (DEPTH),
      .NSLICE    (NSLICE),
      .AW        (AW),
      .SIW       (SIW)
   ) decode_i (
      .addr   (bus_addr),
      .hit    (dec_hit),
      .slice  (dec_slice),
      .offset (dec_off)
   );

   for (genvar s = 0; s < int'(NSLICE); s++) begin : g_slice
      localparam int unsigned SW = bmem_pkg::slice_bits(int'(WORD_W), s);
      logic [SW-1:0] u_rd;
      logic [SW-1:0] b_rd;
      logic          b_we_s;

      assign b_we_s = bus_we && dec_hit && (dec_slice == SIW'(s));

      bmem_slice_bank #(
         .SW    (SW),
         .DEPTH (DEPTH),
         .AW    (AW)
      ) bank_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .u_we   (usr_we),
         .u_addr (usr_addr),
         .u_wd   (usr_wdata[16*s +: SW]),
         .b_we   (b_we_s),
         .b_addr (dec_off),
         .b_wd   (bus_wdata[SW-1:0]),
         .u_rd   (u_rd),
         .b_rd   (b_rd)
      );

      assign usr_word[16*s +: SW] = u_rd;
      assign slice_rd[s]          = 16'(b_rd);
   end

   // user read: registered, read-before-write
   always_ff @(posedge clk) begin
      if (!rst_n) usr_rdata <= '0;
      else        usr_rdata <= usr_word;
   end

   assign rd_req = bus_re && dec_hit;

   bmem_bus_rdpipe #(
      .NSLICE (NSLICE),
      .SIW    (SIW)
   ) rdpipe_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (rd_req),
      .slice    (dec_slice),
      .slice_rd (slice_rd),
      .rdata    (bus_rdata),
      .rvalid   (bus_rvalid)
   );

   // R7: an in-window read strobe returns data two edges later
   a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && dec_hit) |=> ##1 bus_rvalid);

   // R8: a valid strobe always traces back to an in-window read request
   a_r8_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rvalid |-> $past(bus_re && dec_hit, 2));

   // R3: padding bits of the partial top piece read as zero
   if (REM != 0) begin : g_partial_chk
      a_r3_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rvalid && $past(bus_re && dec_hit && (dec_slice == SIW'(LAST)), 2))
            |-> (bus_rdata[15:REM] == '0));
   end

endmodule

// File: tb/bmem_wide_dpram_tb_top.sv
module bmem_wide_dpram_tb_top;

   localparam int W    = 23;
   localparam int D    = 512;
   localparam int BASE = 16'h0040;
   localparam int NS   = (W + 15) / 16;
   localparam int SPAN = NS * D;
   localparam int AW   = $clog2(D);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] usr_addr = '0;
   logic          usr_we = 1'b0;
   logic [W-1:0]  usr_wdata = '0;
   logic [W-1:0]  usr_rdata;
   logic [15:0]   bus_addr = '0;
   logic          bus_we = 1'b0;
   logic          bus_re = 1'b0;
   logic [15:0]   bus_wdata = '0;
   logic [15:0]   bus_rdata;
   logic          bus_rvalid;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bmem_wide_dpram #(.WORD_W(W), .DEPTH(D), .BASE_ADDR(BASE)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .usr_addr(usr_addr), .usr_we(usr_we), .usr_wdata(usr_wdata), .usr_rdata(usr_rdata),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   logic [W-1:0] m [D];
   logic         pv1, pv2;
   logic [15:0]  pd1, pd2;
   logic [W-1:0] eu;

   function automatic logic [15:0] piece_of(input logic [W-1:0] word, input int s);
      return 16'(word >> (16 * s));
   endfunction

   function automatic logic [W-1:0] merge(input logic [W-1:0] word, input int s,
                                          input logic [15:0] d);
      logic [15:0]  mask;
      logic [W-1:0] wm;
      mask = (s < W / 16) ? 16'hFFFF : 16'((1 << (W % 16)) - 1);
      wm   = W'(mask) << (16 * s);
      return (word & ~wm) | (W'(d & mask) << (16 * s));
   endfunction

   always @(posedge clk) begin
      int  rel, sl, off;
      bit  hit;
      if (!rst_n) begin
         for (int i = 0; i < D; i++) m[i] = '0;
         pv1 = 0; pv2 = 0; pd1 = '0; pd2 = '0; eu = '0;
      end else begin
         pv2 = pv1;
         pd2 = pd1;
         rel = int'(bus_addr) - BASE;
         hit = (rel >= 0) && (rel < SPAN);
         sl  = hit ? rel / D : 0;
         off = hit ? rel % D : 0;
         pv1 = bus_re && hit;
         pd1 = (bus_re && hit) ? piece_of(m[off], sl) : 16'd0;
         eu  = m[usr_addr];
         if (bus_we && hit && !(usr_we && (int'(usr_addr) == off)))
            m[off] = merge(m[off], sl, bus_wdata);
         if (usr_we) m[usr_addr] = usr_wdata;
      end
   end

   // compare every cycle, half a period after the edge (R10)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(usr_rdata == eu, "R10 usr_rdata", 32'(usr_rdata), 32'(eu));
         check(bus_rvalid == pv2, "R10 bus_rvalid", 32'(bus_rvalid), 32'(pv2));
         if (pv2) check(bus_rdata == pd2, "R10 bus_rdata", 32'(bus_rdata), 32'(pd2));
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic bus_write(input int a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = 16'(a); bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic bus_read(input int a, output logic v, output logic [15:0] d);
      @(negedge clk);
      bus_addr = 16'(a); bus_re = 1'b1;
      @(negedge clk);
      bus_re = 1'b0;
      @(negedge clk);
      v = bus_rvalid; d = bus_rdata;
   endtask

   task automatic user_write(input int a, input logic [W-1:0] d);
      @(negedge clk);
      usr_addr = AW'(a); usr_wdata = d; usr_we = 1'b1;
      @(negedge clk);
      usr_we = 1'b0;
   endtask

   task automatic user_read(input int a, output logic [W-1:0] d);
      @(negedge clk);
      usr_addr = AW'(a); usr_we = 1'b0;
      @(negedge clk);
      d = usr_rdata;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic         v;
      logic [15:0]  bd;
      logic [W-1:0] ud;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(usr_rdata == '0, "R1 usr_rdata after reset", 32'(usr_rdata), 0);
      check(bus_rvalid == 1'b0, "R1 rvalid after reset", 32'(bus_rvalid), 0);
      bus_read(BASE + 5, v, bd);
      check(v && bd == 16'h0000, "R1 bus low bank zero", 32'(bd), 0);
      bus_read(BASE + D + D - 1, v, bd);
      check(v && bd == 16'h0000, "R1 bus top bank last entry zero", 32'(bd), 0);
      user_read(100, ud);
      check(ud == '0, "R1 user word zero", 32'(ud), 0);

      // R5 / R2: user write visible on both pieces
      user_write(3, 23'h5A1234);
      bus_read(BASE + 3, v, bd);
      check(v && bd == 16'h1234, "R5 R2 low piece", 32'(bd), 32'h1234);
      bus_read(BASE + D + 3, v, bd);
      check(v && bd == 16'h005A, "R2 top piece", 32'(bd), 32'h005A);

      // R3: partial piece keeps only its own bits
      bus_write(BASE + D + 3, 16'hFFFF);
      bus_read(BASE + D + 3, v, bd);
      check(v && bd == 16'h007F, "R3 pad bits dropped", 32'(bd), 32'h007F);
      user_read(3, ud);
      check(ud == 23'h7F1234, "R6 top piece merge", 32'(ud), 32'h7F1234);

      // R6: low piece merge
      bus_write(BASE + 3, 16'hBEEF);
      user_read(3, ud);
      check(ud == 23'h7FBEEF, "R6 low piece merge", 32'(ud), 32'h7FBEEF);

      // R8: just outside both ends of the window
      bus_write(BASE - 1, 16'h1111);
      bus_write(BASE + SPAN, 16'h2222);
      bus_read(BASE - 1, v, bd);
      check(v == 1'b0, "R8 read below window", 32'(v), 0);
      bus_read(BASE + SPAN, v, bd);
      check(v == 1'b0, "R8 read above window", 32'(v), 0);
      user_read(D - 1, ud);
      check(ud == '0, "R8 last word untouched", 32'(ud), 0);
      user_read(0, ud);
      check(ud == '0, "R8 first word untouched", 32'(ud), 0);

      // R9: same-word collision, low piece then top piece
      @(negedge clk);
      usr_addr = 7; usr_wdata = 23'h000111; usr_we = 1'b1;
      bus_addr = 16'(BASE + 7); bus_wdata = 16'hAAAA; bus_we = 1'b1;
      @(negedge clk);
      usr_we = 1'b0; bus_we = 1'b0;
      user_read(7, ud);
      check(ud == 23'h000111, "R9 user wins low piece", 32'(ud), 32'h000111);
      @(negedge clk);
      usr_addr = 9; usr_wdata = 23'h2B0000; usr_we = 1'b1;
      bus_addr = 16'(BASE + D + 9); bus_wdata = 16'h007F; bus_we = 1'b1;
      @(negedge clk);
      usr_we = 1'b0; bus_we = 1'b0;
      user_read(9, ud);
      check(ud == 23'h2B0000, "R9 user wins top piece", 32'(ud), 32'h2B0000);

      // R9: different words in one cycle both land
      @(negedge clk);
      usr_addr = 20; usr_wdata = 23'h123456; usr_we = 1'b1;
      bus_addr = 16'(BASE + 21); bus_wdata = 16'h4321; bus_we = 1'b1;
      @(negedge clk);
      usr_we = 1'b0; bus_we = 1'b0;
      user_read(20, ud);
      check(ud == 23'h123456, "R9 user write kept", 32'(ud), 32'h123456);
      user_read(21, ud);
      check(ud == 23'h004321, "R9 bus write kept", 32'(ud), 32'h004321);

      // R4: user read shows the old word at the writing edge
      @(negedge clk);
      usr_addr = 3; usr_wdata = 23'h0ABCDE; usr_we = 1'b1;
      @(negedge clk);
      check(usr_rdata == 23'h7FBEEF, "R4 read before write", 32'(usr_rdata), 32'h7FBEEF);
      usr_we = 1'b0;
      @(negedge clk);
      check(usr_rdata == 23'h0ABCDE, "R4 one-cycle read", 32'(usr_rdata), 32'h0ABCDE);

      // R7: exact two-edge latency, one-cycle strobe, pre-write data
      @(negedge clk);
      bus_addr = 16'(BASE + 3); bus_re = 1'b1; bus_we = 1'b1; bus_wdata = 16'h5555;
      @(negedge clk);
      bus_re = 1'b0; bus_we = 1'b0;
      check(bus_rvalid == 1'b0, "R7 not valid after one edge", 32'(bus_rvalid), 0);
      @(negedge clk);
      check(bus_rvalid == 1'b1, "R7 valid after two edges", 32'(bus_rvalid), 1);
      check(bus_rdata == 16'hBCDE, "R7 pre-write data", 32'(bus_rdata), 32'hBCDE);
      @(negedge clk);
      check(bus_rvalid == 1'b0, "R7 strobe lasts one cycle", 32'(bus_rvalid), 0);

      // R10: random traffic on both ports, checked by the model every cycle
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         usr_addr  = AW'($urandom_range(D - 1, 0));
         usr_we    = ($urandom_range(3, 0) == 0);
         usr_wdata = W'($urandom);
         bus_addr  = 16'(BASE - 8 + int'($urandom_range(SPAN + 15, 0)));
         bus_we    = ($urandom_range(2, 0) == 0);
         bus_re    = ($urandom_range(1, 0) == 0);
         bus_wdata = 16'($urandom);
      end
      @(negedge clk);
      usr_we = 1'b0; bus_we = 1'b0; bus_re = 1'b0;
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule